// File: doc/BRIEF.md
# Time-Slotted Shared Video Memory Arbiter

This block lets a processor and a display scan-out engine use one single-port video RAM without either side ever waiting. A small phase counter on the pixel clock splits each processor cycle into four pixel-clock slots. The first slot belongs to the display: it reads one 16-bit word, which holds four 4-bit pixels. In the other three slots the display leaves the RAM bus alone and the processor may make one access. The same counter makes the processor clock, so the processor runs at one quarter of the pixel clock and is low only during the display slot.

The fetched word goes into a shift register at the end of the display slot. From there it feeds one pixel per pixel clock, most significant nibble first. Four pixels fill exactly one processor cycle, so scan-out runs without gaps. Outside the visible area the display does not read the RAM, and the pixel output is zero. The pixel stream is fixed-rate and has no back-pressure: the output has a valid flag but no ready input, and a consumer must take one pixel on every pixel clock. The processor side is a plain select/write-enable bus that never stalls.

Top module: `vram_phase_arbiter`

## Requirements
- R1: A synchronous active-high reset sets the slot counter to the display slot (phase 0). While reset is held and in the first cycle after it, `cpu_clk` is 0, `pix_out` is 0, `pix_valid` is 0 and `ram_we` is 0.
- R2: The slot counter advances by one on each pixel clock and wraps after four. `cpu_clk` is 0 in phase 0 and 1 in phases 1, 2 and 3.
- R3: In phase 0, if `disp_active` is 1, `ram_addr` equals `disp_addr`, `ram_cs` is 1 and `ram_we` is 0, whatever the processor bus is doing.
- R4: The word read in phase 0 appears on `pix_out` over the next four cycles (phases 1, 2, 3 and then 0) as bits [15:12], [11:8], [7:4] and [3:0], in that order.
- R5: In phases 1 to 3, if `cpu_sel` is 1, `ram_addr` equals `cpu_addr` and `ram_cs` is 1.
- R6: `ram_we` is 1 only in phase 2, and only when `cpu_sel` and `cpu_we` are both 1. Then `ram_wdata` equals `cpu_wdata`. It is never 1 in phase 1, where ownership changes. A write with `cpu_sel` at 0 leaves memory unchanged.
- R7: A processor read (`cpu_sel` 1, `cpu_we` 0) captures `ram_rdata` at the end of phase 3. From the following phase 0, `cpu_rdata` shows that value.
- R8: If `disp_active` is 0 in phase 0, the RAM is not read for display in that slot. `pix_out` and `pix_valid` are then 0 for the following four cycles.
- R9: In phases 1 to 3, if `cpu_sel` is 0, the RAM bus is released: `ram_cs` is 0 and `ram_addr` is 0.
- R10: Consecutive visible words give an unbroken pixel stream. The last pixel of one word is followed at once by the first pixel of the next, and `pix_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_active | input | 1 | Scan position is inside the visible area |
| disp_addr | input | 8 | Word address for the next display fetch |
| cpu_sel | input | 1 | Processor selects video RAM this cycle |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | 8 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data, held until the next read |
| cpu_clk | output | 1 | Processor clock, one quarter of the pixel clock |
| ram_cs | output | 1 | RAM chip select; 0 when neither side drives the bus |
| ram_addr | output | 8 | RAM address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data (combinational read) |
| pix_out | output | 4 | Current pixel value |
| pix_valid | output | 1 | Pixel belongs to a visible fetch |

## Verification
RAM bus outputs (`ram_cs`, `ram_addr`, `ram_we`, `ram_wdata`) follow the current phase and inputs in the same cycle. The bench changes inputs on the falling edge and checks these outputs shortly after, before the next rising edge. A pixel appears one edge after its fetch slot and moves one nibble per edge, so each nibble is checked on the falling edge of phases 1, 2, 3 and the following phase 0. Read data is captured on the edge that ends phase 3 and is checked in the next phase 0. Every scenario first locks to phase 0, which it finds by the low level of `cpu_clk`, so all expected values are tied to known slots.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

  // who drives the RAM bus in the current pixel slot
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_DISP = 2'd1,
    OWN_CPU  = 2'd2
  } bus_owner_e;

  // position of the most significant pixel in a word
  function automatic int top_lsb(input int dw, input int pw);
    return dw - pw;
  endfunction

endpackage

// File: rtl/vram_phase_gen.sv
module vram_phase_gen #(
  parameter int SLOTS    = 4,
  parameter int WR_PHASE = 2,
  localparam int PHW     = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [PHW-1:0] phase_o,
  output logic           cpu_clk_o,
  output logic           disp_slot_o,
  output logic           wr_slot_o,
  output logic           last_slot_o
);

  logic [PHW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_q + PHW'(1);
  end

  assign phase_o     = ph_q;
  assign disp_slot_o = (ph_q == '0);
  assign cpu_clk_o   = (ph_q != '0);
  assign wr_slot_o   = (ph_q == PHW'(WR_PHASE));
  assign last_slot_o = (ph_q == PHW'(SLOTS - 1));

  // R2: counter steps by one each pixel clock, wrapping modulo SLOTS
  a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ph_q == $past(ph_q) + PHW'(1));

endmodule

// File: rtl/vram_slot_mux.sv
module vram_slot_mux
  import vram_arb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          disp_slot_i,
  input  logic          wr_slot_i,
  input  logic          last_slot_i,
  input  logic          disp_active_i,
  input  logic [AW-1:0] disp_addr_i,
  input  logic          cpu_sel_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          ram_cs_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_we_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          fetch_o
);

  bus_owner_e     owner;
  logic [DW-1:0]  rdata_q;

  always_comb begin
    if (disp_slot_i)
      owner = disp_active_i ? OWN_DISP : OWN_NONE;
    else
      owner = cpu_sel_i ? OWN_CPU : OWN_NONE;
  end

  always_comb begin
    ram_cs_o    = 1'b0;
    ram_addr_o  = '0;
    ram_we_o    = 1'b0;
    ram_wdata_o = '0;
    unique case (owner)
      OWN_DISP: begin
        ram_cs_o   = 1'b1;
        ram_addr_o = disp_addr_i;
      end
      OWN_CPU: begin
        ram_cs_o   = 1'b1;
        ram_addr_o = cpu_addr_i;
        if (cpu_we_i) begin
          ram_wdata_o = cpu_wdata_i;
          ram_we_o    = wr_slot_i;
        end
      end
      default: ;
    endcase
  end

  assign fetch_o = (owner == OWN_DISP);

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (last_slot_i && cpu_sel_i && !cpu_we_i)
      rdata_q <= ram_rdata_i;
  end

  assign cpu_rdata_o = rdata_q;

  // R6: the write strobe lasts a single pixel clock per processor cycle
  a_r6_we_single: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |=> !ram_we_o);

  // R3: no write strobe while the display holds the bus
  a_r3_disp_no_we: assert property (@(posedge clk) disable iff (rst)
    disp_slot_i |-> !ram_we_o);

  // R9: processor slots with no select leave the bus idle
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    (!disp_slot_i && !cpu_sel_i) |-> (!ram_cs_o && ram_addr_o == '0));

endmodule

// File: rtl/vram_pix_shifter.sv
module vram_pix_shifter
  import vram_arb_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          fetch_i,
  input  logic [DW-1:0] word_i,
  output logic [PW-1:0] pix_o,
  output logic          vld_o
);

  localparam int TOP = top_lsb(DW, PW);

  logic [DW-1:0] sh_q;
  logic          vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= fetch_i ? word_i : '0;
      vld_q <= fetch_i;
    end else begin
      sh_q  <= {sh_q[DW-PW-1:0], {PW{1'b0}}};
    end
  end

  assign pix_o = vld_q ? sh_q[TOP +: PW] : '0;
  assign vld_o = vld_q;

  // R4: the first pixel after a fetch is the top nibble of the fetched word
  a_r4_msb_first: assert property (@(posedge clk) disable iff (rst)
    (load_i && fetch_i) |=> pix_o == $past(word_i[TOP +: PW]));

  // R8: a blanked slot yields a zero pixel
  a_r8_blank_zero: assert property (@(posedge clk) disable iff (rst)
    (load_i && !fetch_i) |=> (pix_o == '0 && !vld_o));

endmodule

// File: rtl/vram_phase_arbiter.sv
module vram_phase_arbiter #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int PW       = 4,
  parameter int WR_PHASE = 2,
  localparam int SLOTS   = DW / PW,
  localparam int PHW     = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          disp_active,
  input  logic [AW-1:0] disp_addr,
  input  logic          cpu_sel,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_clk,
  output logic          ram_cs,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic [PW-1:0] pix_out,
  output logic          pix_valid
);

  logic [PHW-1:0] phase;
  logic           disp_slot;
  logic           wr_slot;
  logic           last_slot;
  logic           fetch;

  vram_phase_gen #(.SLOTS(SLOTS), .WR_PHASE(WR_PHASE)) u_phase (
    .clk         (clk),
    .rst         (rst),
    .phase_o     (phase),
    .cpu_clk_o   (cpu_clk),
    .disp_slot_o (disp_slot),
    .wr_slot_o   (wr_slot),
    .last_slot_o (last_slot)
  );

  vram_slot_mux #(.AW(AW), .DW(DW)) u_mux (
    .clk           (clk),
    .rst           (rst),
    .disp_slot_i   (disp_slot),
    .wr_slot_i     (wr_slot),
    .last_slot_i   (last_slot),
    .disp_active_i (disp_active),
    .disp_addr_i   (disp_addr),
    .cpu_sel_i     (cpu_sel),
    .cpu_we_i      (cpu_we),
    .cpu_addr_i    (cpu_addr),
    .cpu_wdata_i   (cpu_wdata),
    .cpu_rdata_o   (cpu_rdata),
    .ram_rdata_i   (ram_rdata),
    .ram_cs_o      (ram_cs),
    .ram_addr_o    (ram_addr),
    .ram_we_o      (ram_we),
    .ram_wdata_o   (ram_wdata),
    .fetch_o       (fetch)
  );

  vram_pix_shifter #(.DW(DW), .PW(PW)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load_i  (disp_slot),
    .fetch_i (fetch),
    .word_i  (ram_rdata),
    .pix_o   (pix_out),
    .vld_o   (pix_valid)
  );

  // R6: a write strobe only ever appears while the processor clock is high
  a_r6_we_cpu_half: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> cpu_clk);

  // R6: the handover slot right after the display slot carries no write
  a_r6_no_we_handover: assert property (@(posedge clk) disable iff (rst)
    (phase == PHW'(0)) |=> !ram_we);

  // R10: a visible fetch keeps the pixel valid flag up for the next word
  a_r10_valid_hold: assert property (@(posedge clk) disable iff (rst)
    (disp_slot && fetch) |=> pix_valid);

endmodule

// File: tb/test_vram_phase_arbiter.sv
`timescale 1ns/1ps
module test_vram_phase_arbiter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        disp_active = 1'b0;
  logic [7:0]  disp_addr = '0;
  logic        cpu_sel = 1'b0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        cpu_clk;
  logic        ram_cs;
  logic [7:0]  ram_addr;
  logic        ram_we;
  logic [15:0] ram_wdata;
  logic [15:0] ram_rdata;
  logic [3:0]  pix_out;
  logic        pix_valid;

  int checks = 0;
  int errors = 0;
  logic [15:0] mem [0:255];

  always #2.5 clk = ~clk;

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 16'h1357) ^ 16'hA5C3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
    end
  end

  assign ram_rdata = ram_cs ? mem[ram_addr] : 16'h0000;

  vram_phase_arbiter i_vram_phase_arbiter (
    .clk(clk), .rst(rst), .disp_active(disp_active), .disp_addr(disp_addr),
    .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_clk(cpu_clk), .ram_cs(ram_cs), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .pix_out(pix_out), .pix_valid(pix_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  // lock onto a falling edge inside phase 0
  task automatic sync_ph0();
    @(negedge clk);
    for (int n = 0; n < 8 && cpu_clk !== 1'b0; n++) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    eq("R1 cpu_clk", cpu_clk, 0);
    eq("R1 pix_out", pix_out, 0);
    eq("R1 pix_valid", pix_valid, 0);
    eq("R1 ram_we", ram_we, 0);
    rst = 1'b0;
  endtask

  task automatic t_phase();
    sync_ph0();
    eq("R2 ph0 cpu_clk", cpu_clk, 0);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      eq("R2 cpu_clk high", cpu_clk, 1);
    end
    @(negedge clk);
    eq("R2 wrap cpu_clk", cpu_clk, 0);
  endtask

  task automatic t_pixels();
    logic [15:0] wa, wb;
    wa = pat(8'h21); wb = pat(8'h22);
    sync_ph0();
    disp_active = 1'b1; disp_addr = 8'h21;
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h77;
    #1;
    eq("R3 ram_addr", ram_addr, 8'h21);
    eq("R3 ram_cs", ram_cs, 1);
    eq("R3 ram_we", ram_we, 0);
    cpu_sel = 1'b0; cpu_we = 1'b0;
    for (int k = 3; k >= 0; k--) begin
      @(negedge clk);
      eq("R4 nibble", pix_out, 32'(wa[k*4 +: 4]));
      eq("R10 valid", pix_valid, 1);
    end
    disp_addr = 8'h22;
    #1;
    eq("R10 next fetch addr", ram_addr, 8'h22);
    for (int k = 3; k >= 0; k--) begin
      @(negedge clk);
      eq("R10 next word nibble", pix_out, 32'(wb[k*4 +: 4]));
      eq("R10 valid", pix_valid, 1);
    end
  endtask

  task automatic t_blank();
    sync_ph0();
    disp_active = 1'b0;
    #1;
    eq("R8 no fetch", ram_cs, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      eq("R8 pix zero", pix_out, 0);
      eq("R8 valid low", pix_valid, 0);
    end
    eq("R8 no fetch again", ram_cs, 0);
  endtask

  task automatic t_release();
    sync_ph0();
    cpu_sel = 1'b0; cpu_addr = 8'h5A;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      eq("R9 ram_cs", ram_cs, 0);
      eq("R9 ram_addr", ram_addr, 0);
    end
  endtask

  task automatic t_write(input logic [7:0] a, input logic [15:0] d);
    sync_ph0();
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    eq("R5 ram_addr ph1", ram_addr, 32'(a));
    eq("R5 ram_cs ph1", ram_cs, 1);
    eq("R6 no we ph1", ram_we, 0);
    @(negedge clk);
    eq("R6 we ph2", ram_we, 1);
    eq("R6 wdata", ram_wdata, 32'(d));
    @(negedge clk);
    eq("R6 no we ph3", ram_we, 0);
    @(negedge clk);
    eq("R6 no we ph0", ram_we, 0);
    cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic t_read(input logic [7:0] a, input logic [15:0] exp, input string req);
    sync_ph0();
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    eq("R5 read addr", ram_addr, 32'(a));
    repeat (3) @(negedge clk);
    eq(req, cpu_rdata, 32'(exp));
    cpu_sel = 1'b0;
  endtask

  task automatic t_unselected_write();
    sync_ph0();
    cpu_sel = 1'b0; cpu_we = 1'b1; cpu_addr = 8'h40; cpu_wdata = 16'hDEAD;
    repeat (2) @(negedge clk);
    eq("R6 no we without sel", ram_we, 0);
    repeat (2) @(negedge clk);
    cpu_we = 1'b0;
    t_read(8'h40, pat(8'h40), "R6 unselected write ignored");
  endtask

  initial begin
    t_reset();
    t_phase();
    t_pixels();
    t_blank();
    t_release();
    t_write(8'h33, 16'hBEEF);
    t_read(8'h33, 16'hBEEF, "R7 read back write");
    t_read(8'h90, pat(8'h90), "R7 read preload");
    t_unselected_write();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule